// File: doc/BRIEF.md
# Windowed Register File Controller

This block holds the integer registers of a processor that uses register windows, together with the logic that manages those windows. An instruction sees 32 architectural registers through a 5-bit number. The eight globals are shared by every window. The eight locals are private to one window. The eight outs of one window are the same storage as the eight ins of the window above it. A caller therefore places arguments and its return address in its outs. After the callee performs a save, the callee finds those values in its ins, and no data is copied.

The pipeline drives two combinational read ports and one write port, and pulses a save or restore strobe. The window controller moves the current window pointer up on a save and down on a restore, modulo the number of windows. It keeps the savable and restorable window counts in step. When no window is free in the requested direction, the controller leaves all state alone and, in the next cycle, raises a spill or fill trap request with a suggested trap type for the handler. An alternate-globals select swaps globals 1 to 7 for a second bank during trap handling.

The controller is a three-state machine:
- States: `ST_IDLE` (no request), `ST_SPILL` (overflow request shown), `ST_FILL` (underflow request shown).
- Transitions:
  - From any state to `ST_SPILL` on a save while the savable count is 0.
  - From any state to `ST_FILL` on a restore (without save) while the restorable count is 0.
  - Otherwise from any state to `ST_IDLE`.

Top module: `winreg_file`

## Requirements
- R1: Register number 0 reads as zero on both read ports in every window and bank, and a write to it changes nothing.
- R2: Register numbers 0 to 7 are globals, and the same storage is seen from every window.
- R3: Out register k of window W (number 8+k) and in register k of window (W+1) mod N (number 24+k) are one storage element. A value written to number 15 before a save therefore reads back from number 31 after it.
- R4: Numbers 16 to 23 are locals private to each window. A local written in one window is not seen in another, and it is still there when that window is re-entered.
- R5: A save strobe with a savable count above 0 adds 1 to the window pointer (mod N), lowers the savable count by 1 and raises the restorable count by 1, all visible in the cycle after the strobe's edge. A restore strobe with a restorable count above 0 does the reverse.
- R6: A save strobe while the savable count is 0 leaves the pointer and counters unchanged. For exactly the following cycle it raises trap_req with trap_is_fill = 0 and trap_type = SPILL_TT (default 8'h80, range 8'h80 to 8'hBF).
- R7: A restore strobe (without save) while the restorable count is 0 leaves the pointer and counters unchanged. For exactly the following cycle it raises trap_req with trap_is_fill = 1 and trap_type = FILL_TT (default 8'hC0, range 8'hC0 to 8'hFF).
- R8: The savable count plus the restorable count always equals N - 2. The other-windows count is held at zero.
- R9: With alt_glb = 1, numbers 1 to 7 select a separate bank of alternate globals. With alt_glb = 0 they select the normal bank. Neither bank disturbs the other.
- R10: A read of the register being written in the same cycle returns the new write data.
- R11: After reset the window pointer is 0, the savable count is N - 2, the restorable count is 0, trap_req is 0, and all storage reads zero.
- R12: When save and restore strobes arrive together, only the save acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alt_glb | input | 1 | Select alternate globals for numbers 1 to 7 |
| rd_a_idx | input | 5 | Read port A register number |
| rd_a_data | output | XLEN | Read port A data |
| rd_b_idx | input | 5 | Read port B register number |
| rd_b_data | output | XLEN | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Save strobe |
| restore_req | input | 1 | Restore strobe |
| cwp | output | log2(NWIN) | Current window pointer |
| cansave | output | log2(NWIN) | Savable window count |
| canrestore | output | log2(NWIN) | Restorable window count |
| trap_req | output | 1 | Spill or fill trap request |
| trap_is_fill | output | 1 | 1 for a fill request, 0 for a spill request |
| trap_type | output | 8 | Suggested trap type, 0 when no request |

## Verification
A window pointer that is off by one makes ins, outs and locals resolve to a neighbouring window's storage. This appears at the read ports in the first read after the faulty save or restore, as a return address or argument that is missing or stale. A wrong savable or restorable count appears at once on the count outputs. It also moves the spill or fill request one strobe early or late, and that shows on trap_req in the cycle after the strobe. A wrong bank or aliasing decision appears as zero or foreign data on the next read of a register that was written earlier.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPILL = 2'd1,
        ST_FILL  = 2'd2
    } wctl_state_e;

    typedef enum logic [1:0] {
        RC_GLOBAL = 2'd0,
        RC_OUT    = 2'd1,
        RC_LOCAL  = 2'd2,
        RC_IN     = 2'd3
    } reg_class_e;

endpackage

// File: rtl/winreg_map.sv
module winreg_map
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN),
    localparam int PW = CW + 5
) (
    input  logic [4:0]    arch_idx,
    input  logic [CW-1:0] cur_win,
    input  logic          alt_sel,
    output logic [PW-1:0] phys_idx,
    output logic          is_zero
);

    reg_class_e    rclass;
    logic [2:0]    slot;
    logic [CW-1:0] up_win;

    assign rclass  = reg_class_e'(arch_idx[4:3]);
    assign slot    = arch_idx[2:0];
    assign up_win  = cur_win + 1'b1;
    assign is_zero = (arch_idx == 5'd0);

    always_comb begin
        unique case (rclass)
            RC_GLOBAL: phys_idx = alt_sel ? PW'({2'b01, slot}) : PW'({2'b00, slot});
            RC_OUT:    phys_idx = PW'(16) + PW'({up_win, 4'b0000}) + PW'(slot);
            RC_LOCAL:  phys_idx = PW'(24) + PW'({cur_win, 4'b0000}) + PW'(slot);
            RC_IN:     phys_idx = PW'(16) + PW'({cur_win, 4'b0000}) + PW'(slot);
            default:   phys_idx = '0;
        endcase
    end

endmodule

// File: rtl/winreg_store.sv
module winreg_store #(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    parameter int NRD  = 2,
    localparam int PW    = $clog2(NWIN) + 5,
    localparam int DEPTH = 16 + 16 * NWIN
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [PW-1:0]             wr_phys,
    input  logic                      wr_zero,
    input  logic [XLEN-1:0]           wr_data,
    input  logic [NRD-1:0][PW-1:0]    rd_phys,
    input  logic [NRD-1:0]            rd_zero,
    output logic [NRD-1:0][XLEN-1:0]  rd_data
);

    logic [XLEN-1:0] mem [DEPTH];
    logic            wr_live;

    assign wr_live = wr_en && !wr_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_live) begin
            mem[wr_phys] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rd_zero[p])
                rd_data[p] = '0;
            else if (wr_live && (wr_phys == rd_phys[p]))
                rd_data[p] = wr_data;
            else
                rd_data[p] = mem[rd_phys[p]];
        end
    end

endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl
    import winreg_pkg::*;
#(
    parameter int         NWIN     = 8,
    parameter logic [7:0] SPILL_TT = 8'h80,
    parameter logic [7:0] FILL_TT  = 8'hC0,
    localparam int CW = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_req,
    input  logic          restore_req,
    output logic [CW-1:0] cwp,
    output logic [CW-1:0] cansave,
    output logic [CW-1:0] canrestore,
    output logic          trap_req,
    output logic          trap_is_fill,
    output logic [7:0]    trap_type
);

    localparam logic [CW-1:0] FREE_INIT = CW'(NWIN - 2);

    wctl_state_e state_q, state_d;
    logic do_save, do_rest, spill_hit, fill_hit;

    assign do_save   = save_req;
    assign do_rest   = restore_req && !save_req;
    assign spill_hit = do_save && (cansave == '0);
    assign fill_hit  = do_rest && (canrestore == '0);

    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_SPILL, ST_FILL: begin
                if (spill_hit)     state_d = ST_SPILL;
                else if (fill_hit) state_d = ST_FILL;
                else               state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cwp        <= '0;
            cansave    <= FREE_INIT;
            canrestore <= '0;
        end else if (do_save && !spill_hit) begin
            cwp        <= cwp + 1'b1;
            cansave    <= cansave - 1'b1;
            canrestore <= canrestore + 1'b1;
        end else if (do_rest && !fill_hit) begin
            cwp        <= cwp - 1'b1;
            cansave    <= cansave + 1'b1;
            canrestore <= canrestore - 1'b1;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_SPILL: begin
                trap_req     = 1'b1;
                trap_is_fill = 1'b0;
                trap_type    = SPILL_TT;
            end
            ST_FILL: begin
                trap_req     = 1'b1;
                trap_is_fill = 1'b1;
                trap_type    = FILL_TT;
            end
            default: begin
                trap_req     = 1'b0;
                trap_is_fill = 1'b0;
                trap_type    = 8'h00;
            end
        endcase
    end

endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
    parameter int         NWIN     = 8,
    parameter int         XLEN     = 32,
    parameter logic [7:0] SPILL_TT = 8'h80,
    parameter logic [7:0] FILL_TT  = 8'hC0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alt_glb,
    input  logic [4:0]              rd_a_idx,
    output logic [XLEN-1:0]         rd_a_data,
    input  logic [4:0]              rd_b_idx,
    output logic [XLEN-1:0]         rd_b_data,
    input  logic                    wr_en,
    input  logic [4:0]              wr_idx,
    input  logic [XLEN-1:0]         wr_data,
    input  logic                    save_req,
    input  logic                    restore_req,
    output logic [$clog2(NWIN)-1:0] cwp,
    output logic [$clog2(NWIN)-1:0] cansave,
    output logic [$clog2(NWIN)-1:0] canrestore,
    output logic                    trap_req,
    output logic                    trap_is_fill,
    output logic [7:0]              trap_type
);

    localparam int PW  = $clog2(NWIN) + 5;
    localparam int NRD = 2;

    logic [NRD-1:0][4:0]      rd_arch;
    logic [NRD-1:0][PW-1:0]   rd_phys;
    logic [NRD-1:0]           rd_zero;
    logic [NRD-1:0][XLEN-1:0] rd_data;
    logic [PW-1:0]            wr_phys;
    logic                     wr_zero;

    assign rd_arch[0] = rd_a_idx;
    assign rd_arch[1] = rd_b_idx;
    assign rd_a_data  = rd_data[0];
    assign rd_b_data  = rd_data[1];

    winreg_ctrl #(.NWIN(NWIN), .SPILL_TT(SPILL_TT), .FILL_TT(FILL_TT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
        .cwp(cwp), .cansave(cansave), .canrestore(canrestore),
        .trap_req(trap_req), .trap_is_fill(trap_is_fill), .trap_type(trap_type)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rmap
        winreg_map #(.NWIN(NWIN)) u_map (
            .arch_idx(rd_arch[p]), .cur_win(cwp), .alt_sel(alt_glb),
            .phys_idx(rd_phys[p]), .is_zero(rd_zero[p])
        );
    end

    winreg_map #(.NWIN(NWIN)) u_wmap (
        .arch_idx(wr_idx), .cur_win(cwp), .alt_sel(alt_glb),
        .phys_idx(wr_phys), .is_zero(wr_zero)
    );

    winreg_store #(.NWIN(NWIN), .XLEN(XLEN), .NRD(NRD)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_phys(wr_phys),
        .wr_zero(wr_zero), .wr_data(wr_data), .rd_phys(rd_phys),
        .rd_zero(rd_zero), .rd_data(rd_data)
    );

endmodule

// File: rtl/winreg_chk.sv
module winreg_chk #(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    localparam int CW = $clog2(NWIN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            save_req,
    input logic            restore_req,
    input logic [4:0]      rd_a_idx,
    input logic [XLEN-1:0] rd_a_data,
    input logic [CW-1:0]   cwp,
    input logic [CW-1:0]   cansave,
    input logic [CW-1:0]   canrestore,
    input logic            trap_req,
    input logic            trap_is_fill,
    input logic [7:0]      trap_type
);

    AST_G0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0)); // R1

    AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && cansave != '0) |=>
        (cwp == CW'($past(cwp) + 1'b1)) && (cansave == CW'($past(cansave) - 1'b1))); // R5

    AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!save_req && restore_req && canrestore != '0) |=>
        (cwp == CW'($past(cwp) - 1'b1)) && (canrestore == CW'($past(canrestore) - 1'b1))); // R5

    AST_SPILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && cansave == '0) |=>
        trap_req && !trap_is_fill && trap_type[7:6] == 2'b10 && $stable(cwp) && $stable(cansave)); // R6

    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!save_req && restore_req && canrestore == '0) |=>
        trap_req && trap_is_fill && trap_type[7:6] == 2'b11 && $stable(cwp) && $stable(canrestore)); // R7

    AST_COUNT_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cansave) + 32'(canrestore)) == 32'(NWIN - 2)); // R8

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cwp == '0) && (canrestore == '0) && !trap_req); // R11

endmodule

bind winreg_file winreg_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .cwp(cwp), .cansave(cansave),
    .canrestore(canrestore), .trap_req(trap_req), .trap_is_fill(trap_is_fill),
    .trap_type(trap_type)
);

// File: tb/winreg_file_tb.sv
module winreg_file_tb;

    localparam int NWIN = 8;
    localparam int XLEN = 32;
    localparam int NV   = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alt_glb = 1'b0;
    logic [4:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
    logic [2:0] cwp, cansave, canrestore;
    logic trap_req, trap_is_fill;
    logic [7:0] trap_type;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    winreg_file #(.NWIN(NWIN), .XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .alt_glb(alt_glb),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .cwp(cwp), .cansave(cansave), .canrestore(canrestore),
        .trap_req(trap_req), .trap_is_fill(trap_is_fill), .trap_type(trap_type)
    );

    // entry: op(2) 0=write 1=read-check 2=save 3=restore, req(4), reg(5), data(32)
    localparam logic [42:0] TBL [NV] = '{
        {2'd0, 4'd3, 5'd15, 32'hA100_0007},  // R3 return address into out 7
        {2'd0, 4'd4, 5'd16, 32'hB000_0010},  // R4 local of window 0
        {2'd0, 4'd2, 5'd1,  32'hC000_0001},  // R2 global 1
        {2'd0, 4'd1, 5'd0,  32'hDEAD_BEEF},  // R1 write to zero register
        {2'd1, 4'd1, 5'd0,  32'h0000_0000},  // R1
        {2'd2, 4'd5, 5'd0,  32'h0},          // save to window 1
        {2'd1, 4'd3, 5'd31, 32'hA100_0007},  // R3 seen as in 7
        {2'd1, 4'd4, 5'd16, 32'h0000_0000},  // R4 fresh local
        {2'd1, 4'd2, 5'd1,  32'hC000_0001},  // R2 global shared
        {2'd0, 4'd4, 5'd16, 32'hB100_0010},  // R4 local of window 1
        {2'd0, 4'd3, 5'd8,  32'hA200_0000},  // R3 out 0 of window 1
        {2'd2, 4'd5, 5'd0,  32'h0},          // save to window 2
        {2'd1, 4'd3, 5'd24, 32'hA200_0000},  // R3 in 0 of window 2
        {2'd3, 4'd5, 5'd0,  32'h0},          // restore to window 1
        {2'd3, 4'd5, 5'd0,  32'h0},          // restore to window 0
        {2'd1, 4'd4, 5'd16, 32'hB000_0010},  // R4 local kept
        {2'd1, 4'd3, 5'd15, 32'hA100_0007},  // R3 back as out 7
        {2'd1, 4'd2, 5'd1,  32'hC000_0001}   // R2
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        save_req = 1'b0;
        restore_req = 1'b0;
    endtask

    task automatic do_write(input logic [4:0] r, input logic [31:0] d);
        wr_en = 1'b1; wr_idx = r; wr_data = d;
        tick();
    endtask

    task automatic read_a(input string tag, input logic [4:0] r, input logic [31:0] exp);
        rd_a_idx = r;
        #1 check(tag, rd_a_data, exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        check("R11 cwp", 32'(cwp), 0);
        check("R11 cansave", 32'(cansave), NWIN - 2);
        check("R11 canrestore", 32'(canrestore), 0);
        check("R11 trap_req", 32'(trap_req), 0);
        read_a("R11 storage", 5'd17, 0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [3:0] rq;
            op = TBL[i][42:41];
            rq = TBL[i][40:37];
            case (op)
                2'd0: begin wr_en = 1'b1; wr_idx = TBL[i][36:32]; wr_data = TBL[i][31:0]; end
                2'd1: begin
                    rd_a_idx = TBL[i][36:32];
                    #1 check($sformatf("R%0d table step %0d", rq, i), rd_a_data, TBL[i][31:0]);
                end
                2'd2: save_req = 1'b1;
                default: restore_req = 1'b1;
            endcase
            tick();
        end

        // R9 alternate globals
        do_write(5'd3, 32'h0000_0333);
        alt_glb = 1'b1;
        read_a("R9 alt bank empty", 5'd3, 0);
        do_write(5'd3, 32'hAAAA_0003);
        read_a("R9 alt bank value", 5'd3, 32'hAAAA_0003);
        read_a("R1 zero with alt", 5'd0, 0);
        alt_glb = 1'b0;
        read_a("R9 normal bank kept", 5'd3, 32'h0000_0333);

        // R10 read during write
        wr_en = 1'b1; wr_idx = 5'd20; wr_data = 32'h1234_5678;
        rd_b_idx = 5'd20;
        #1 check("R10 bypass port b", rd_b_data, 32'h1234_5678);
        tick();
        #1 check("R10 stored", rd_b_data, 32'h1234_5678);
        rd_b_idx = 5'd0;
        #1 check("R1 zero on port b", rd_b_data, 0);

        // R5 save until full
        for (int k = 1; k <= NWIN - 2; k++) begin
            save_req = 1'b1;
            tick();
            #1;
            check($sformatf("R5 save %0d cwp", k), 32'(cwp), k);
            check($sformatf("R5 save %0d cansave", k), 32'(cansave), NWIN - 2 - k);
            check($sformatf("R8 save %0d sum", k), 32'(cansave) + 32'(canrestore), NWIN - 2);
        end

        // R6 spill on full
        save_req = 1'b1;
        tick();
        #1;
        check("R6 trap_req", 32'(trap_req), 1);
        check("R6 trap_is_fill", 32'(trap_is_fill), 0);
        check("R6 trap_type", 32'(trap_type), 32'h80);
        check("R6 cwp held", 32'(cwp), NWIN - 2);
        check("R6 canrestore held", 32'(canrestore), NWIN - 2);
        tick();
        #1 check("R6 request one cycle", 32'(trap_req), 0);

        // R12 save and restore together: save wins, spills
        save_req = 1'b1; restore_req = 1'b1;
        tick();
        #1;
        check("R12 spill not fill", 32'(trap_is_fill), 0);
        check("R12 trap_req", 32'(trap_req), 1);
        check("R12 cwp held", 32'(cwp), NWIN - 2);
        tick();

        // R5 restore back to window 0
        for (int k = NWIN - 3; k >= 0; k--) begin
            restore_req = 1'b1;
            tick();
            #1;
            check($sformatf("R5 restore to %0d cwp", k), 32'(cwp), k);
            check($sformatf("R5 restore to %0d canrestore", k), 32'(canrestore), k);
        end
        read_a("R10 value in window 0", 5'd20, 32'h1234_5678);

        // R7 fill on empty
        restore_req = 1'b1;
        tick();
        #1;
        check("R7 trap_req", 32'(trap_req), 1);
        check("R7 trap_is_fill", 32'(trap_is_fill), 1);
        check("R7 trap_type", 32'(trap_type), 32'hC0);
        check("R7 cwp held", 32'(cwp), 0);
        check("R7 cansave held", 32'(cansave), NWIN - 2);
        tick();
        #1 check("R7 request one cycle", 32'(trap_req), 0);

        finish_run();
    end

endmodule